// File: doc/BRIEF.md
# UART Control Register and Interrupt Request Generator

This block holds the 8-bit control word of a small UART and turns the UART's events into one-clock interrupt request pulses for an external interrupt controller. Software writes and reads the control word through a plain write strobe, write data and a combinational read-back bus. The block also holds the UART's data staging. A two-entry receive buffer is filled by a load strobe from the receive shifter and drained by a read strobe, oldest byte first. A one-entry transmit buffer takes bytes from a push strobe and hands them to the transmit shift register when that register reports it is idle.

Three separate request outputs are produced: receive error, receive buffer reached its threshold, and transmit buffer emptied into the shifter. The receive threshold is programmable to one or two buffered bytes. Clearing the enable bit stops all traffic and empties both buffers. Serial shifting, baud timing, framing and the status word are outside the block. They appear only as strobes and the exported occupancy count.

Top module: `uart_ctl_irq`

## Requirements
- R1: After reset the control read-back is 0x00, the receive count is 0, the transmit buffer is empty, and no request or start pulse is asserted.
- R2: Control bit layout: bit 0 enables the UART, bit 1 selects the receive threshold (0 means one byte, 1 means two bytes), bit 4 enables the transmit-empty request, bit 5 enables the receive-threshold request, and bit 6 enables the receive-error request. Bits 7, 3 and 2 always read back as 0.
- R3: With bit 1 = 0 and bit 5 = 1, a load that takes the receive count from 0 to 1 raises irq_rx_full for exactly one cycle. That cycle is the first in which rx_count shows 1. A second load makes no pulse.
- R4: With bit 1 = 1 and bit 5 = 1, the first load makes no pulse. The load that takes the count from 1 to 2 raises irq_rx_full for one cycle.
- R5: When the transmit buffer holds a byte and shifter_ready is high, tx_start pulses for one cycle with that byte on tx_shift_data, and the buffer empties. irq_tx_empty pulses in the same cycle only when bit 4 = 1.
- R6: A rising edge of rx_err_evt raises irq_rx_err for one cycle when bit 6 = 1. Holding the input high makes no further pulses. With bit 6 = 0 there is no pulse.
- R7: rx_head presents the oldest stored byte, and each read strobe removes it. A read strobe on an empty buffer leaves the count at 0.
- R8: A load into a full buffer without a read in the same cycle is dropped. The stored bytes are kept and still come out in order. The dropped load counts as a receive error (irq_rx_err when bit 6 = 1).
- R9: A load and a read in the same cycle leave the count unchanged, advance the head to the next byte, and make no threshold pulse.
- R10: Changing bit 1 while bytes are buffered makes no threshold pulse.
- R11: A write with bit 0 = 0 empties both buffers: on the next cycle rx_count is 0 and tx_full is 0.
- R12: While bit 0 is 0, loads, pushes, error events and shifter_ready have no effect: the count stays 0, tx_full stays 0, and no pulse appears.
- R13: With bit 5 = 0, a load that reaches the threshold makes no irq_rx_full pulse, but the byte is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| rx_load | input | 1 | Receive shifter delivers a byte |
| rx_load_data | input | 8 | Byte delivered by the receive shifter |
| rx_pop | input | 1 | Read strobe that removes the oldest received byte |
| rx_head | output | 8 | Oldest received byte |
| rx_count | output | 2 | Number of bytes held in the receive buffer |
| rx_err_evt | input | 1 | Receive error condition from framing or parity logic |
| tx_push | input | 1 | Write strobe into the transmit buffer |
| tx_push_data | input | 8 | Byte written into the transmit buffer |
| tx_full | output | 1 | Transmit buffer holds a byte |
| shifter_ready | input | 1 | Transmit shift register is idle |
| tx_start | output | 1 | One-cycle pulse: byte moved into the shifter |
| tx_shift_data | output | 8 | Byte handed to the shifter |
| irq_rx_err | output | 1 | Receive error request pulse |
| irq_rx_full | output | 1 | Receive threshold request pulse |
| irq_tx_empty | output | 1 | Transmit buffer empty request pulse |

## Verification
The bench targets the edges of the threshold logic. It checks a second byte at the one-byte setting, a first byte at the two-byte setting, a load and read in the same cycle, and a threshold flip while bytes sit in the buffer. A design that compares levels rather than transitions would fire repeatedly or retroactively in these cases. A design that adds the load before subtracting the read would fire on a count it never settled at. The bench also loads into a full buffer and drives a held error input: an overwrite shows up as a wrong byte at the head, and a level-sensitive error request shows up as extra pulses. Finally it disables the UART with both buffers occupied and then drives traffic while disabled. A missing flush leaves a stale count or a pending start, and missing gating produces pulses the scoreboard does not expect.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

    localparam int CFG_W    = 8;
    localparam int EN_BIT   = 0;
    localparam int THR_BIT  = 1;
    localparam int TXE_BIT  = 4;
    localparam int RXF_BIT  = 5;
    localparam int ERR_BIT  = 6;

    typedef struct packed {
        logic err_en;
        logic full_en;
        logic txe_en;
        logic two_thr;
        logic uart_en;
    } cfg_t;

endpackage

// File: rtl/uart_ctl_cfg.sv
module uart_ctl_cfg
    import uart_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cfg_t             cfg_o,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             xfer_active
);

    cfg_t cfg_d, cfg_q;
    logic unused_rsvd;

    assign unused_rsvd = ^{cfg_wdata[7], cfg_wdata[3:2]};

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.err_en  = cfg_wdata[ERR_BIT];
            cfg_d.full_en = cfg_wdata[RXF_BIT];
            cfg_d.txe_en  = cfg_wdata[TXE_BIT];
            cfg_d.two_thr = cfg_wdata[THR_BIT];
            cfg_d.uart_en = cfg_wdata[EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Read-back: reserved positions stay zero.
    always_comb begin
        cfg_rdata          = '0;
        cfg_rdata[ERR_BIT] = cfg_q.err_en;
        cfg_rdata[RXF_BIT] = cfg_q.full_en;
        cfg_rdata[TXE_BIT] = cfg_q.txe_en;
        cfg_rdata[THR_BIT] = cfg_q.two_thr;
        cfg_rdata[EN_BIT]  = cfg_q.uart_en;
    end

    // A write clearing the enable takes effect on traffic in the same cycle.
    assign xfer_active = cfg_q.uart_en & ~(cfg_we & ~cfg_wdata[EN_BIT]);
    assign cfg_o       = cfg_q;

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  cnt_q_o,
    output logic [CNT_W-1:0]  cnt_d_o,
    output logic              overrun
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd_ptr;
        logic [PTR_W-1:0]             wr_ptr;
        logic [CNT_W-1:0]             cnt;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      is_full, do_pop, do_load;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        is_full = (st_q.cnt == CNT_W'(DEPTH));
        do_pop  = active & pop & (st_q.cnt != '0);
        do_load = active & load & (~is_full | do_pop);
        overrun = active & load & is_full & ~do_pop;

        if (do_pop) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        if (do_load) begin
            st_d.mem[st_q.wr_ptr] = load_data;
            st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
        end
        st_d.cnt = st_q.cnt + CNT_W'(do_load) - CNT_W'(do_pop);

        if (!active) begin
            st_d.cnt    = '0;
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head    = st_q.mem[st_q.rd_ptr];
    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              shifter_ready,
    output logic              full,
    output logic              start,
    output logic [DATA_W-1:0] shift_data,
    output logic              handoff
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              start;
        logic [DATA_W-1:0] shift_data;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        handoff    = active & st_q.full & shifter_ready;
        st_d.start = handoff;
        if (handoff) begin
            st_d.shift_data = st_q.data;
            st_d.full       = 1'b0;
        end
        if (active && push && (!st_q.full || handoff)) begin
            st_d.full = 1'b1;
            st_d.data = push_data;
        end
        if (!active) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full       = st_q.full;
    assign start      = st_q.start;
    assign shift_data = st_q.shift_data;

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             err_en,
    input  logic             full_en,
    input  logic             txe_en,
    input  logic             two_thr,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             overrun,
    input  logic             err_evt,
    input  logic             handoff,
    output logic             irq_err,
    output logic             irq_full,
    output logic             irq_txe
);

    typedef struct packed {
        logic err_prev;
        logic err;
        logic full;
        logic txe;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr           = two_thr ? CNT_W'(2) : CNT_W'(1);
        st_d          = st_q;
        st_d.err_prev = err_evt;
        // Crossing the threshold upward is the only trigger.
        st_d.full     = active & full_en & (cnt_q < thr) & (cnt_d >= thr);
        st_d.err      = active & err_en & ((err_evt & ~st_q.err_prev) | overrun);
        st_d.txe      = txe_en & handoff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_err  = st_q.err;
    assign irq_full = st_q.full;
    assign irq_txe  = st_q.txe;

endmodule

// File: rtl/uart_ctl_irq.sv
module uart_ctl_irq
    import uart_ctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 2,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_load_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_head,
    output logic [CNT_W-1:0]  rx_count,
    input  logic              rx_err_evt,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    output logic              tx_full,
    input  logic              shifter_ready,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_shift_data,
    output logic              irq_rx_err,
    output logic              irq_rx_full,
    output logic              irq_tx_empty
);

    cfg_t             cfg;
    logic             active;
    logic [CNT_W-1:0] cnt_next;
    logic             overrun;
    logic             handoff;
    logic             unused_en;

    assign unused_en = cfg.uart_en;

    uart_ctl_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_o       (cfg),
        .cfg_rdata   (cfg_rdata),
        .xfer_active (active)
    );

    uart_rx_buf #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .load      (rx_load),
        .load_data (rx_load_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .cnt_q_o   (rx_count),
        .cnt_d_o   (cnt_next),
        .overrun   (overrun)
    );

    uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .push          (tx_push),
        .push_data     (tx_push_data),
        .shifter_ready (shifter_ready),
        .full          (tx_full),
        .start         (tx_start),
        .shift_data    (tx_shift_data),
        .handoff       (handoff)
    );

    uart_irq_gen #(.CNT_W(CNT_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .err_en   (cfg.err_en),
        .full_en  (cfg.full_en),
        .txe_en   (cfg.txe_en),
        .two_thr  (cfg.two_thr),
        .cnt_q    (rx_count),
        .cnt_d    (cnt_next),
        .overrun  (overrun),
        .err_evt  (rx_err_evt),
        .handoff  (handoff),
        .irq_err  (irq_rx_err),
        .irq_full (irq_rx_full),
        .irq_txe  (irq_tx_empty)
    );

endmodule

// File: rtl/uart_ctl_irq_chk.sv
module uart_ctl_irq_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic [7:0]       cfg_rdata,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_full,
    input logic             tx_start,
    input logic             irq_rx_err,
    input logic             irq_rx_full,
    input logic             irq_tx_empty
);

    // R3
    full_on_count_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_full |-> (rx_count != $past(rx_count)));

    // R3
    full_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_full |=> !irq_rx_full);

    // R5
    start_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(tx_full));

    // R11
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[0]) |=> (rx_count == '0 && !tx_full));

    // R12
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_rdata[0]) |-> !(irq_rx_err || irq_rx_full || irq_tx_empty || tx_start));

endmodule

bind uart_ctl_irq uart_ctl_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .rx_count     (rx_count),
    .tx_full      (tx_full),
    .tx_start     (tx_start),
    .irq_rx_err   (irq_rx_err),
    .irq_rx_full  (irq_rx_full),
    .irq_tx_empty (irq_tx_empty)
);

// File: tb/uart_ctl_irq_tb_top.sv
module uart_ctl_irq_tb_top;

    localparam int K_ERR  = 0;
    localparam int K_FULL = 1;
    localparam int K_TXS  = 2;
    localparam int K_TXE  = 3;

    typedef struct {
        int    kind;
        int    data;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       rx_load = 1'b0;
    logic [7:0] rx_load_data = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_head;
    logic [1:0] rx_count;
    logic       rx_err_evt = 1'b0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_push_data = '0;
    logic       tx_full;
    logic       shifter_ready = 1'b0;
    logic       tx_start;
    logic [7:0] tx_shift_data;
    logic       irq_rx_err, irq_rx_full, irq_tx_empty;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    uart_ctl_irq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_load(rx_load), .rx_load_data(rx_load_data),
        .rx_pop(rx_pop), .rx_head(rx_head), .rx_count(rx_count),
        .rx_err_evt(rx_err_evt), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_full(tx_full), .shifter_ready(shifter_ready), .tx_start(tx_start),
        .tx_shift_data(tx_shift_data), .irq_rx_err(irq_rx_err),
        .irq_rx_full(irq_rx_full), .irq_tx_empty(irq_tx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int data, input string req);
        exp_t e;
        e.kind = kind; e.data = data; e.req = req;
        sb.push_back(e);
    endtask

    task automatic seen(input int kind, input int data);
        exp_t e;
        if (sb.size() == 0) begin
            chk(1'b0, "unexpected pulse", kind, -1);
        end else begin
            e = sb.pop_front();
            chk(e.kind == kind && (kind != K_TXS || e.data == data), e.req,
                kind * 256 + data, e.kind * 256 + e.data);
        end
    endtask

    // Monitor: outputs are registered, sampled half a period after the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_rx_err)   seen(K_ERR, 0);
            if (irq_rx_full)  seen(K_FULL, 0);
            if (tx_start)     seen(K_TXS, int'(tx_shift_data));
            if (irq_tx_empty) seen(K_TXE, 0);
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic rx(input bit ld, input logic [7:0] d, input bit pp);
        rx_load = ld; rx_load_data = d; rx_pop = pp;
        cyc();
        rx_load = 1'b0; rx_pop = 1'b0;
    endtask

    task automatic drained(input string req);
        cyc(); cyc();
        chk(sb.size() == 0, req, sb.size(), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) cyc();
                rst_n = 1'b1;
                cyc();
                // R1: reset state
                chk(cfg_rdata == 8'h00, "R1", cfg_rdata, 0);
                chk(rx_count == 0 && !tx_full, "R1", {rx_count, tx_full}, 0);
                chk(!(irq_rx_err | irq_rx_full | irq_tx_empty | tx_start), "R1", 1, 0);

                // R2: reserved bits read back zero
                wr_cfg(8'hFF);
                chk(cfg_rdata == 8'h73, "R2", cfg_rdata, 8'h73);
                wr_cfg(8'h71);
                chk(cfg_rdata == 8'h71, "R2", cfg_rdata, 8'h71);

                // R3: one-byte threshold
                expect_ev(K_FULL, 0, "R3");
                rx(1, 8'hA1, 0);
                chk(rx_count == 1, "R3", rx_count, 1);
                rx(1, 8'hB2, 0);
                chk(rx_count == 2, "R3", rx_count, 2);
                // R7: oldest first, pop on empty
                chk(rx_head == 8'hA1, "R7", rx_head, 8'hA1);
                rx(0, 0, 1);
                chk(rx_head == 8'hB2, "R7", rx_head, 8'hB2);
                rx(0, 0, 1);
                rx(0, 0, 1);
                chk(rx_count == 0, "R7", rx_count, 0);
                drained("R3");

                // R8: overrun keeps data, flags error
                expect_ev(K_FULL, 0, "R8");
                rx(1, 8'hC3, 0);
                rx(1, 8'hD4, 0);
                expect_ev(K_ERR, 0, "R8");
                rx(1, 8'hE5, 0);
                chk(rx_count == 2 && rx_head == 8'hC3, "R8", rx_head, 8'hC3);
                rx(0, 0, 1);
                chk(rx_head == 8'hD4, "R8", rx_head, 8'hD4);
                rx(0, 0, 1);
                drained("R8");

                // R4: two-byte threshold
                wr_cfg(8'h73);
                rx(1, 8'h11, 0);
                chk(rx_count == 1, "R4", rx_count, 1);
                drained("R4");
                expect_ev(K_FULL, 0, "R4");
                rx(1, 8'h22, 0);
                chk(rx_count == 2, "R4", rx_count, 2);
                drained("R4");
                // R10: threshold flips with bytes present
                wr_cfg(8'h71);
                wr_cfg(8'h73);
                rx(0, 0, 1);
                wr_cfg(8'h71);
                drained("R10");
                rx(0, 0, 1);
                chk(rx_count == 0, "R10", rx_count, 0);

                // R9: simultaneous load and read
                expect_ev(K_FULL, 0, "R9");
                rx(1, 8'h33, 0);
                rx(1, 8'h44, 1);
                chk(rx_count == 1 && rx_head == 8'h44, "R9", rx_head, 8'h44);
                rx(0, 0, 1);
                drained("R9");

                // R6: held error input gives one pulse
                expect_ev(K_ERR, 0, "R6");
                rx_err_evt = 1'b1;
                repeat (3) cyc();
                rx_err_evt = 1'b0;
                drained("R6");
                wr_cfg(8'h31);
                rx_err_evt = 1'b1; cyc(); rx_err_evt = 1'b0;
                drained("R6");

                // R5: transmit hand-off
                wr_cfg(8'h71);
                tx_push = 1'b1; tx_push_data = 8'h5A; cyc(); tx_push = 1'b0;
                chk(tx_full && !tx_start, "R5", tx_full, 1);
                expect_ev(K_TXS, 8'h5A, "R5");
                expect_ev(K_TXE, 0, "R5");
                shifter_ready = 1'b1; cyc(); shifter_ready = 1'b0;
                chk(!tx_full, "R5", tx_full, 0);
                wr_cfg(8'h61);
                tx_push = 1'b1; tx_push_data = 8'h6B; cyc(); tx_push = 1'b0;
                expect_ev(K_TXS, 8'h6B, "R5");
                shifter_ready = 1'b1; cyc(); shifter_ready = 1'b0;
                drained("R5");

                // R13: threshold request disabled
                wr_cfg(8'h51);
                rx(1, 8'h77, 0);
                chk(rx_count == 1 && rx_head == 8'h77, "R13", rx_head, 8'h77);
                rx(0, 0, 1);
                drained("R13");

                // R11: disable flushes
                wr_cfg(8'h71);
                expect_ev(K_FULL, 0, "R11");
                rx(1, 8'h81, 0);
                rx(1, 8'h82, 0);
                tx_push = 1'b1; tx_push_data = 8'h83; cyc(); tx_push = 1'b0;
                wr_cfg(8'h70);
                chk(rx_count == 0, "R11", rx_count, 0);
                chk(!tx_full, "R11", tx_full, 0);

                // R12: traffic ignored while disabled
                rx_load = 1'b1; rx_load_data = 8'h85; tx_push = 1'b1;
                rx_err_evt = 1'b1; shifter_ready = 1'b1;
                cyc();
                rx_load = 1'b0; tx_push = 1'b0; rx_err_evt = 1'b0;
                cyc();
                shifter_ready = 1'b0;
                chk(rx_count == 0, "R12", rx_count, 0);
                chk(!tx_full, "R12", tx_full, 0);
                drained("R12");
                wr_cfg(8'h71);
                expect_ev(K_FULL, 0, "R11");
                rx(1, 8'h91, 0);
                chk(rx_count == 1 && rx_head == 8'h91, "R11", rx_head, 8'h91);
                drained("R11");
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule